// File: doc/BRIEF.md
# Slot-Based Prescaled PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control word. Software writes that word through a synchronous write strobe and reads it back unchanged, so it can change one field and leave the others as they are. The word holds a run bit, an idle output level, an 8-bit clock divider and an 8-bit low-time count.

Each output period is split into 256 equal slots. A slot lasts as many clock cycles as the divider says, and a divider value of zero stands for 256. A period opens with its low phase, which lasts as many slots as the low-time count, and then stays high for the rest of the period. While the run bit is clear, the output shows the idle level. Divider and low-time changes written during a running period are held back until the next period begins, so no period is ever cut short.

Top module: `duty_slot_pwm`

## Requirements
- R1: A synchronous active-high reset clears the whole control word, so `rd_data` reads 0 and `pwm_out` is 0 after reset.
- R2: Every write sets the control word. The field positions are: bit 31 run, bit 30 idle level, bits 15:8 divider, bits 7:0 low-time count. These bits read back exactly as written on the cycle after the write, and bits 29:16 always read 0.
- R3: While bit 31 is 0, `pwm_out` equals bit 30.
- R4: A slot lasts N clock cycles, where N is the divider for values 1 to 255 and N is 256 for a divider of 0. A full period therefore lasts 256 × N cycles.
- R5: With a low-time count of D, each period shows `pwm_out` low for D × N cycles and then high for (256 − D) × N cycles. When D is 0 the output stays high.
- R6: A divider or low-time value written while the block is running takes effect only at the start of the next period. The period already in progress keeps its original timing.
- R7: Writing 0 to bit 31 puts the output at the newly written idle level on the cycle after the write and clears the counters. Writing 1 to bit 31 from the stopped state starts a fresh period at slot 0, beginning with the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures the length of each low run and each high run on the output, taken directly after the block is started. This is repeated for several combinations of divider and low-time count:
- Unit divider with the low-time count at 1, at the midpoint and at 255 shows whether the slot comparison is off by one at either end.
- Odd dividers and a divider of 0 show whether the prescaler terminal count, including the 256 wraparound, scales the slot length correctly.
- A low-time count of 0 shows that the output stays high throughout.

Directed cases cover the following:
- A write in the middle of a period that changes both fields at once. The first period must keep its old lengths and the next period must take the new ones.
- Stopping the block during the high phase and restarting it.
- Readback of all bits with the unused bits set in the write data.

// File: rtl/duty_slot_pwm.sv
module duty_slot_pwm (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam int RUN_BIT  = 31;
  localparam int IDLE_BIT = 30;
  localparam int FW       = 8;
  localparam logic [FW-1:0] LAST_SLOT = '1;

  logic          run_q, idle_q;
  logic [FW-1:0] div_q, low_q;
  logic [FW-1:0] act_div, act_low;
  logic [FW-1:0] pre_q, slot_q;

  logic          run_n, idle_n;
  logic [FW-1:0] div_n, low_n;
  logic [FW-1:0] pre_term;
  logic          pre_last;

  assign run_n    = wr_en ? wr_data[RUN_BIT]  : run_q;
  assign idle_n   = wr_en ? wr_data[IDLE_BIT] : idle_q;
  assign div_n    = wr_en ? wr_data[2*FW-1:FW] : div_q;
  assign low_n    = wr_en ? wr_data[FW-1:0]    : low_q;

  // divider 0 wraps to a terminal count of 255, i.e. 256 cycles per slot
  assign pre_term = act_div - 8'd1;
  assign pre_last = (pre_q == pre_term);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      idle_q  <= 1'b0;
      div_q   <= '0;
      low_q   <= '0;
      act_div <= '0;
      act_low <= '0;
      pre_q   <= '0;
      slot_q  <= '0;
    end else begin
      run_q  <= run_n;
      idle_q <= idle_n;
      div_q  <= div_n;
      low_q  <= low_n;
      if (!run_n || !run_q) begin
        pre_q   <= '0;
        slot_q  <= '0;
        act_div <= div_n;
        act_low <= low_n;
      end else if (pre_last) begin
        pre_q  <= '0;
        slot_q <= slot_q + 8'd1;
        if (slot_q == LAST_SLOT) begin
          act_div <= div_n;
          act_low <= low_n;
        end
      end else begin
        pre_q <= pre_q + 8'd1;
      end
    end
  end

  assign rd_data = {run_q, idle_q, 14'd0, div_q, low_q};
  assign pwm_out = run_q ? (slot_q >= act_low) : idle_q;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rd_data == 32'd0 && pwm_out == 1'b0));

  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[31:30] == $past(wr_data[31:30]) &&
               rd_data[15:0]  == $past(wr_data[15:0])));

  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    !rd_data[RUN_BIT] |-> (pwm_out == rd_data[IDLE_BIT]));

  a_r4_slot_step: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && !$stable(slot_q)) |-> $past(pre_q == pre_term));

  a_r5_rise_at_duty: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && $rose(pwm_out)) |-> (slot_q == act_low && pre_q == '0));

  a_r6_period_boundary: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && !($stable(act_low) && $stable(act_div)))
      |-> (slot_q == '0 && pre_q == '0));

  a_r7_stop_idle: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[RUN_BIT]) |=> (pwm_out == $past(wr_data[IDLE_BIT])));
endmodule

// File: tb/duty_slot_pwm_tb_top.sv
module duty_slot_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  duty_slot_pwm dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  localparam int NV = 7;
  // {divider, low-time count}
  localparam logic [15:0] VEC [NV] = '{
    {8'd1, 8'd1}, {8'd1, 8'd128}, {8'd1, 8'd255}, {8'd2, 8'd64},
    {8'd3, 8'd200}, {8'd5, 8'd10}, {8'd1, 8'd0}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_len(input logic lvl, input int limit, output int n);
    n = 0;
    while (pwm_out === lvl && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] word(input bit run, input bit idle, input logic [7:0] dv, input logic [7:0] lo);
    return {run, idle, 14'd0, dv, lo};
  endfunction

  initial begin
    #(190000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lo_n, hi_n, nd, d, lo2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 32'd0, "R1 rd_data", rd_data, 0);
    check(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);

    for (int i = 0; i < NV; i++) begin
      nd = (VEC[i][15:8] == 0) ? 256 : VEC[i][15:8];
      d  = VEC[i][7:0];
      wr(word(1'b1, 1'b0, VEC[i][15:8], VEC[i][7:0]));
      if (d == 0) begin
        run_len(1'b1, 3 * 256 * nd, hi_n);
        check(hi_n == 3 * 256 * nd, "R5 zero count stays high", hi_n, 3 * 256 * nd);
      end else begin
        run_len(1'b0, 300 * nd, lo_n);
        check(lo_n == d * nd, "R5 low run", lo_n, d * nd);
        run_len(1'b1, 300 * nd, hi_n);
        check(hi_n == (256 - d) * nd, "R5 high run", hi_n, (256 - d) * nd);
        check(lo_n + hi_n == 256 * nd, "R4 period", lo_n + hi_n, 256 * nd);
      end
      wr(word(1'b0, 1'b0, 8'd0, 8'd0));
      check(pwm_out == 1'b0, "R3 idle low", pwm_out, 0);
    end

    // R2 / R3 readback with unused bits set
    wr(32'h7FFF_FFFF);
    check(rd_data == 32'h4000_FFFF, "R2 readback", rd_data, 32'h4000_FFFF);
    check(pwm_out == 1'b1, "R3 idle high", pwm_out, 1);
    wr(32'h0000_0000);
    check(pwm_out == 1'b0, "R3 idle low", pwm_out, 0);

    // R4 divider 0 means 256
    wr(word(1'b1, 1'b0, 8'd0, 8'd1));
    run_len(1'b0, 1000, lo_n);
    check(lo_n == 256, "R4 divider zero low", lo_n, 256);
    run_len(1'b1, 70000, hi_n);
    check(hi_n == 255 * 256, "R4 divider zero high", hi_n, 255 * 256);
    wr(word(1'b0, 1'b0, 8'd0, 8'd0));

    // R6 mid-period change applies at next period
    wr(word(1'b1, 1'b0, 8'd1, 8'd100));
    fork
      begin
        repeat (5) @(negedge clk);
        wr_en = 1'b1;
        wr_data = word(1'b1, 1'b0, 8'd2, 8'd200);
        @(negedge clk);
        wr_en = 1'b0;
      end
      begin
        run_len(1'b0, 2000, lo_n);
        run_len(1'b1, 2000, hi_n);
        run_len(1'b0, 2000, lo2);
      end
    join
    check(lo_n == 100, "R6 old low kept", lo_n, 100);
    check(hi_n == 156, "R6 old high kept", hi_n, 156);
    check(lo2 == 400, "R6 new low applied", lo2, 400);
    check(rd_data == word(1'b1, 1'b0, 8'd2, 8'd200), "R2 readback running", rd_data, word(1'b1, 1'b0, 8'd2, 8'd200));

    // R7 stop during high phase, then restart
    wr(word(1'b0, 1'b0, 8'd0, 8'd0));
    wr(word(1'b1, 1'b0, 8'd1, 8'd50));
    run_len(1'b0, 1000, lo_n);
    repeat (20) @(negedge clk);
    check(pwm_out == 1'b1, "R5 high phase", pwm_out, 1);
    wr(word(1'b0, 1'b1, 8'd1, 8'd50));
    check(pwm_out == 1'b1 && rd_data[31] == 1'b0, "R7 stop to idle high", pwm_out, 1);
    wr(word(1'b0, 1'b0, 8'd1, 8'd50));
    check(pwm_out == 1'b0, "R7 stop to idle low", pwm_out, 0);
    wr(word(1'b1, 1'b0, 8'd1, 8'd50));
    run_len(1'b0, 1000, lo_n);
    check(lo_n == 50, "R7 restart at slot 0", lo_n, 50);

    // R1 reset while running
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(rd_data == 32'd0 && pwm_out == 1'b0, "R1 reset while running", rd_data, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule